// File: doc/BRIEF.md
# Recursive Sinusoidal Tone Generator

This block makes a fixed-frequency sine tone with a two-state recursive resonator in signed fractional fixed point, one sample per accepted input. Each accepted input beat carries a stereo pair of audio samples. The block advances the resonator one step. It emits the new tone sample together with the left and right inputs, each with the tone added and saturated. This gives a "signal plus hum" pair, used to corrupt an audio stream with a known interference tone.

The resonator holds a coefficient C = cos(2π·f/Fs) and two states. The first state holds the most recent tone sample and the second holds the one before it. Reset loads these three values from parameters. The defaults give a 60 Hz tone at 48 kHz with amplitude 0.3 and phase 0: C = 0x7FFEFD, first state 0xFFB2CB, second state 0xFF6597. A load strobe replaces all three from input ports. The trigonometric constants are computed outside the block, and amplitude drift is not corrected.

Both data interfaces use valid/ready. An input beat transfers when `in_valid` and `in_ready` are both high. The single output register accepts a new beat when it is empty, or when its current beat leaves in the same cycle. When `out_valid` is high and `out_ready` is low, the output beat is held unchanged and `in_ready` is low. No stepping of the resonator happens without a transfer.

Top module: `hum_tone_injector`

## Requirements
- R1: After reset, `out_valid` is 0 and all outputs are 0. The states are the parameter defaults, so the first beat accepted after reset carries tone value 0x000000.
- R2: Each step computes new = floor((P + 2^21) / 2^22) − s2, wrapped to 24 bits. P is the 48-bit signed product of C and s1, and all values are 1.23 two's-complement fractions. This equals 2·C·s1 − s2, rounded half up.
- R3: After a step, s2 takes the old s1 and s1 takes the new value. With the default states, the second beat after reset carries tone 0x004D35.
- R4: `tone_out` is the new first state. It appears with `out_valid` high on the clock edge after the input transfer.
- R5: The same tone sample is added to `left_in` and to `right_in` of the same beat, giving `left_out` and `right_out`.
- R6: Each sum saturates to 0x7FFFFF above the range and to 0x800000 below it, and never wraps.
- R7: `in_ready` = (!`out_valid` || `out_ready`) && !`load_en`. While `out_valid` is high and `out_ready` is low, all outputs hold stable.
- R8: While `load_en` is high, no input beat is accepted. On that edge C, s1 and s2 take `load_coef`, `load_s1` and `load_s2`, and later steps start from these values.
- R9: Cycles without a transfer leave C and both states unchanged, so the tone sequence continues across gaps and stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Load strobe for coefficient and states |
| load_coef | input | 24 | Coefficient C to load (1.23) |
| load_s1 | input | 24 | First state to load (1.23) |
| load_s2 | input | 24 | Second state to load (1.23) |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| left_in | input | 24 | Left audio sample (1.23) |
| right_in | input | 24 | Right audio sample (1.23) |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the output beat |
| tone_out | output | 24 | Tone sample of the beat (1.23) |
| left_out | output | 24 | Left plus tone, saturated |
| right_out | output | 24 | Right plus tone, saturated |

## Verification
`in_ready` is combinational and is compared in the same cycle as its inputs. The tone and both sums are due on the rising edge after the transfer, so the bench samples them at the following falling edge. A stalled beat is due unchanged on every edge until `out_ready` rises. The reference model steps only when a transfer occurs, so gaps, stalls and loads move the expected sequence by exactly as many samples as the design should.

// File: rtl/tone_pkg.sv
package tone_pkg;

  // Default 60 Hz at 48 kHz, amplitude 0.3, phase 0 (1.23 fractions)
  localparam logic [23:0] DEF_COEF = 24'h7FFEFD;
  localparam logic [23:0] DEF_S1   = 24'hFFB2CB;
  localparam logic [23:0] DEF_S2   = 24'hFF6597;

  typedef enum logic [1:0] {
    STEP_HOLD    = 2'd0,
    STEP_LOAD    = 2'd1,
    STEP_ADVANCE = 2'd2
  } step_e;

endpackage

// File: rtl/tone_recur.sv
module tone_recur #(
  parameter int DW = 24
) (
  input  logic [DW-1:0] coef,
  input  logic [DW-1:0] s1,
  input  logic [DW-1:0] s2,
  output logic [DW-1:0] nxt
);
  localparam int PW   = 2 * DW;
  localparam int FRAC = DW - 1;
  localparam int SHR  = FRAC - 1;   // doubling folded into the shift
  localparam logic signed [PW-1:0] RND = PW'(1) << (SHR - 1);

  logic signed [PW-1:0]   prod;
  logic signed [PW-1:0]   prod_r;
  logic signed [DW+1:0]   dbl;
  logic signed [DW+1:0]   diff;
  logic                   unused_bits;

  assign prod   = $signed(coef) * $signed(s1);
  assign prod_r = prod + RND;
  assign dbl    = prod_r[SHR +: DW+2];
  assign diff   = dbl - {{2{s2[DW-1]}}, s2};
  assign nxt    = diff[DW-1:0];
  assign unused_bits = ^{prod_r[SHR-1:0], prod_r[PW-1:SHR+DW+2], diff[DW+1:DW]};
endmodule

// File: rtl/tone_sat_add.sv
module tone_sat_add #(
  parameter int DW = 24
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

  logic [DW:0] sum;
  logic        ovf;

  assign sum = {a[DW-1], a} + {b[DW-1], b};
  assign ovf = sum[DW] ^ sum[DW-1];

  always_comb begin
    if (!ovf)        y = sum[DW-1:0];
    else if (sum[DW]) y = NEG_MIN;
    else              y = POS_MAX;
  end
endmodule

// File: rtl/tone_state.sv
module tone_state
  import tone_pkg::*;
#(
  parameter int          DW        = 24,
  parameter logic [DW-1:0] COEF_INIT = DEF_COEF,
  parameter logic [DW-1:0] S1_INIT   = DEF_S1,
  parameter logic [DW-1:0] S2_INIT   = DEF_S2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  step_e         step,
  input  logic [DW-1:0] ld_coef,
  input  logic [DW-1:0] ld_s1,
  input  logic [DW-1:0] ld_s2,
  input  logic [DW-1:0] nxt,
  output logic [DW-1:0] coef,
  output logic [DW-1:0] s1,
  output logic [DW-1:0] s2
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef <= COEF_INIT;
      s1   <= S1_INIT;
      s2   <= S2_INIT;
    end else begin
      unique case (step)
        STEP_LOAD: begin
          coef <= ld_coef;
          s1   <= ld_s1;
          s2   <= ld_s2;
        end
        STEP_ADVANCE: begin
          s2 <= s1;
          s1 <= nxt;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hum_tone_injector.sv
module hum_tone_injector
  import tone_pkg::*;
#(
  parameter int            DW        = 24,
  parameter logic [DW-1:0] COEF_INIT = DEF_COEF,
  parameter logic [DW-1:0] S1_INIT   = DEF_S1,
  parameter logic [DW-1:0] S2_INIT   = DEF_S2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [DW-1:0] load_coef,
  input  logic [DW-1:0] load_s1,
  input  logic [DW-1:0] load_s2,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] left_in,
  input  logic [DW-1:0] right_in,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] tone_out,
  output logic [DW-1:0] left_out,
  output logic [DW-1:0] right_out
);
  localparam int NCH = 2;

  logic          accept;
  step_e         step;
  logic [DW-1:0] coef, s1, s2, nxt;
  logic [DW-1:0] ch_in  [NCH];
  logic [DW-1:0] ch_sum [NCH];
  logic [DW-1:0] ch_q   [NCH];

  assign in_ready = (!out_valid || out_ready) && !load_en;
  assign accept   = in_valid && in_ready;

  always_comb begin
    if (load_en)     step = STEP_LOAD;
    else if (accept) step = STEP_ADVANCE;
    else             step = STEP_HOLD;
  end

  tone_state #(
    .DW(DW), .COEF_INIT(COEF_INIT), .S1_INIT(S1_INIT), .S2_INIT(S2_INIT)
  ) u_state (
    .clk(clk), .rst_n(rst_n), .step(step),
    .ld_coef(load_coef), .ld_s1(load_s1), .ld_s2(load_s2),
    .nxt(nxt), .coef(coef), .s1(s1), .s2(s2)
  );

  tone_recur #(.DW(DW)) u_recur (
    .coef(coef), .s1(s1), .s2(s2), .nxt(nxt)
  );

  assign ch_in[0] = left_in;
  assign ch_in[1] = right_in;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    tone_sat_add #(.DW(DW)) u_sat (
      .a(ch_in[c]), .b(nxt), .y(ch_sum[c])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ch_q[c] <= '0;
      else if (accept) ch_q[c] <= ch_sum[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      tone_out  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      tone_out  <= nxt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign left_out  = ch_q[0];
  assign right_out = ch_q[1];
endmodule

// File: rtl/hum_tone_checker.sv
module hum_tone_checker #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_en,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] left_in,
  input logic [DW-1:0] right_in,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] tone_out,
  input logic [DW-1:0] left_out,
  input logic [DW-1:0] right_out
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(tone_out) && $stable(left_out) && $stable(right_out)); // R7

  AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> !in_ready); // R8

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R4

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && !(in_valid && in_ready) |=> !out_valid); // R4

  AST_NO_WRAP_POS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(in_valid && in_ready) && !$past(left_in[DW-1]) && !tone_out[DW-1]
      |-> !left_out[DW-1]); // R6

  AST_NO_WRAP_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(in_valid && in_ready) && $past(right_in[DW-1]) && tone_out[DW-1]
      |-> right_out[DW-1]); // R6
endmodule

bind hum_tone_injector hum_tone_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_en(load_en), .in_valid(in_valid),
  .in_ready(in_ready), .left_in(left_in), .right_in(right_in),
  .out_valid(out_valid), .out_ready(out_ready), .tone_out(tone_out),
  .left_out(left_out), .right_out(right_out)
);

// File: tb/test_hum_tone_injector.sv
`timescale 1ns/1ps
module test_hum_tone_injector;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_en;
  logic [23:0] load_coef, load_s1, load_s2;
  logic        in_valid;
  logic        in_ready;
  logic [23:0] left_in, right_in;
  logic        out_valid;
  logic        out_ready;
  logic [23:0] tone_out, left_out, right_out;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // reference model state
  logic [23:0] m_coef = 24'h7FFEFD;
  logic [23:0] m_s1   = 24'hFFB2CB;
  logic [23:0] m_s2   = 24'hFF6597;
  logic        m_valid = 1'b0;
  logic [23:0] m_tone = '0, m_l = '0, m_r = '0;

  always #2.5 clk = ~clk;

  hum_tone_injector i_hum_tone_injector (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_coef(load_coef),
    .load_s1(load_s1), .load_s2(load_s2), .in_valid(in_valid),
    .in_ready(in_ready), .left_in(left_in), .right_in(right_in),
    .out_valid(out_valid), .out_ready(out_ready), .tone_out(tone_out),
    .left_out(left_out), .right_out(right_out)
  );

  function automatic logic [23:0] ref_next(logic [23:0] c, logic [23:0] a, logic [23:0] b);
    longint p, q, d;
    p = longint'($signed(c)) * longint'($signed(a));
    q = (p + (longint'(1) << 21)) >>> 22;
    d = q - longint'($signed(b));
    return d[23:0];
  endfunction

  function automatic logic [23:0] ref_sat(logic [23:0] a, logic [23:0] b);
    longint s;
    s = longint'($signed(a)) + longint'($signed(b));
    if (s > 64'sd8388607)  return 24'h7FFFFF;
    if (s < -64'sd8388608) return 24'h800000;
    return s[23:0];
  endfunction

  task automatic check(input logic [23:0] act, input logic [23:0] exp, input string tag, input string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic tick(input logic iv, input logic [23:0] l, input logic [23:0] r,
                      input logic ordy, input logic ld, input logic [23:0] lc,
                      input logic [23:0] ls1, input logic [23:0] ls2, input string tag);
    logic exp_rdy;
    logic [23:0] t;
    in_valid = iv; left_in = l; right_in = r; out_ready = ordy;
    load_en = ld; load_coef = lc; load_s1 = ls1; load_s2 = ls2;
    #1;
    exp_rdy = (!m_valid || ordy) && !ld;
    check({23'd0, in_ready}, {23'd0, exp_rdy}, "R7", "in_ready");
    @(posedge clk);
    if (ld) begin
      m_coef = lc; m_s1 = ls1; m_s2 = ls2;
    end
    if (iv && exp_rdy) begin
      t = ref_next(m_coef, m_s1, m_s2);
      m_tone = t; m_l = ref_sat(l, t); m_r = ref_sat(r, t);
      m_s2 = m_s1; m_s1 = t; m_valid = 1'b1;
    end else if (ordy) begin
      m_valid = 1'b0;
    end
    @(negedge clk);
    check({23'd0, out_valid}, {23'd0, m_valid}, "R4", "out_valid");
    if (m_valid) begin
      check(tone_out, m_tone, tag, "tone_out");
      check(left_out, m_l, "R5", "left_out");
      check(right_out, m_r, "R6", "right_out");
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; load_en = 0; load_coef = 0; load_s1 = 0; load_s2 = 0;
    in_valid = 0; left_in = 0; right_in = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({23'd0, out_valid}, 24'd0, "R1", "out_valid in reset");
    check(tone_out, 24'd0, "R1", "tone_out in reset");
    check(left_out, 24'd0, "R1", "left_out in reset");
    rst_n = 1'b1;

    tick(0, 0, 0, 1, 0, 0, 0, 0, "R9");
    tick(0, 0, 0, 1, 0, 0, 0, 0, "R9");
    // R1 / R2: first tone from default states is zero
    tick(1, 24'h000100, 24'hFFFF00, 1, 0, 0, 0, 0, "R2");
    check(tone_out, 24'h000000, "R1", "first tone");
    // R3: second tone after state shift
    tick(1, 24'h123456, 24'hEDCBA9, 1, 0, 0, 0, 0, "R3");
    check(tone_out, 24'h004D35, "R3", "second tone");

    // R5: steady stream with varied audio
    for (int i = 0; i < 60; i++)
      tick(1, 24'(i * 24'h01F3A5), 24'(24'h800000 + i * 24'h00A1B7), 1, 0, 0, 0, 0, "R2");

    // R9: gaps keep the phase
    for (int i = 0; i < 30; i++)
      tick(i % 3 == 0, 24'(i * 3), 24'(i * 5), 1, 0, 0, 0, 0, "R9");

    // R7: back-pressure
    for (int i = 0; i < 40; i++)
      tick(1, 24'(i * 24'h013579), 24'(~i), (i % 5 == 2), 0, 0, 0, 0, "R7");
    tick(0, 0, 0, 1, 0, 0, 0, 0, "R7");

    // R8: load while an input is offered
    tick(1, 24'h111111, 24'h222222, 1, 1, 24'h7FF000, 24'h200000, 24'h1F0000, "R8");
    for (int i = 0; i < 20; i++)
      tick(1, 24'(i * 24'h0F0F0F), 24'(i * 24'h070707), 1, 0, 0, 0, 0, "R8");
    // R8 with a stalled output beat pending
    tick(1, 24'h1, 24'h2, 0, 0, 0, 0, 0, "R8");
    tick(1, 24'h3, 24'h4, 0, 1, 24'h400000, 24'h000000, 24'h300000, "R8");
    for (int i = 0; i < 6; i++)
      tick(1, 24'(i), 24'(i), 1, 0, 0, 0, 0, "R8");

    // R6: saturation both ways (tone alternates -0x100000, 0, +0x100000)
    tick(0, 0, 0, 1, 1, 24'h000000, 24'h000000, 24'h100000, "R6");
    for (int i = 0; i < 8; i++)
      tick(1, 24'h7FFFFF, 24'h800000, 1, 0, 0, 0, 0, "R6");
    for (int i = 0; i < 4; i++)
      tick(1, 24'h7FFFF0, 24'h800010, 1, 0, 0, 0, 0, "R6");

    // back to defaults, then a long mixed run
    tick(0, 0, 0, 1, 1, 24'h7FFEFD, 24'hFFB2CB, 24'hFF6597, "R8");
    for (int i = 0; i < 2500; i++)
      tick(($urandom % 4) != 0, 24'($urandom), 24'($urandom), ($urandom % 4) != 0,
           0, 0, 0, 0, "R3");

    finish_run();
  end
endmodule